// File: doc/BRIEF.md
# I2C Message-List Transaction Sequencer

This block turns a list of I2C messages into the per-byte command words that a command-FIFO I2C master consumes. Each message is held in a small descriptor memory as a target address, a direction bit and a byte count. On a `go` pulse the sequencer first checks the whole list. It then enables the master and walks the messages in order. For a write it takes bytes from an input byte stream and pushes them as write commands. For a read it pushes one read command per byte and returns each received byte on an output byte stream.

Between steps the sequencer watches the master's FIFO and abort status. It watches every wait with a timeout counter and collects all failures into one OR-ed result code. On the first failure it skips the rest of the list. When the transaction ends, for whatever reason, it drops the master's enable and polls the enable-status input at a fixed interval. If the master still reports itself enabled after the last poll, the sequencer issues an abort. A one-cycle `done` strobe then presents the result code.

Top module: `i2c_msglist_seq`

## Requirements
- R1: The first message's address and direction are recorded without a RESTART. Any later message whose address or direction (desc_rd, 1 = read) differs from the recorded pair carries `cmd_restart` on its first command only, and the recorded pair then becomes that message's.
- R2: `cmd_stop` is set on the final command of the final message in the list and on no other command.
- R3: An empty list (`msg_count` = 0) or any message with length 0 ends the transaction with result 0x10. No command is pushed and `ctl_enable` is never raised.
- R4: Write commands (`cmd_rd` = 0) are pushed only in a cycle where both `fifo_tx_notfull` and `wr_valid` are high. The data bytes keep the order of the stream, and `wr_take` marks each byte consumed.
- R5: After the last byte of a write message, the sequencer waits for `fifo_tx_empty` and then samples `abrt_flag`. With the flag set, the result gains 0x02 when `abrt_data_nack` is high, else 0x01 when `abrt_addr_nack` is high, else 0x10.
- R6: A read message pushes one command with `cmd_rd` = 1 per byte. It then waits for `fifo_rx_notempty`, pops the byte with `rx_pop` and shows it on `rd_data` with `rd_valid`. If `abrt_addr_nack` is seen during the wait, the result gains 0x01.
- R7: A wait that lasts WAIT_CYC cycles (for FIFO room, stream data, TX empty or RX data) adds 0x08 to the result and ends the transaction.
- R8: On the first error, no further commands are pushed and `ctl_clear` pulses. `ctl_clear` also pulses once at the start of every message.
- R9: At the end of every transaction that raised `ctl_enable`, `ctl_enable` falls and `ctl_enabled` is polled up to POLLS times, GAP_CYC cycles apart. If it is still high at the last poll, `ctl_abort` pulses once and the result gains 0x04.
- R10: `done` is high for exactly one cycle per transaction and `result` is valid with it. A transaction with no failure gives result 0.
- R11: While a message runs, `ctl_target` holds that message's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a transaction (taken when idle) |
| msg_count | input | CNT_W | Number of messages in the list |
| desc_idx | output | IDX_W | Descriptor memory read index |
| desc_addr | input | ADDR_W | Target address of the indexed message |
| desc_rd | input | 1 | Direction of the indexed message, 1 = read |
| desc_len | input | LEN_W | Byte count of the indexed message |
| ctl_enable | output | 1 | Enable level to the master |
| ctl_target | output | ADDR_W | Target address to the master |
| ctl_enabled | input | 1 | Enable status reported by the master |
| ctl_clear | output | 1 | Pulse clearing the master's interrupt status |
| ctl_abort | output | 1 | Pulse requesting the master to abort |
| cmd_push | output | 1 | Command word write strobe |
| cmd_byte | output | 8 | Data byte of the command |
| cmd_rd | output | 1 | Command is a read |
| cmd_stop | output | 1 | Send STOP after this command |
| cmd_restart | output | 1 | Send RESTART before this command |
| fifo_tx_notfull | input | 1 | Master command FIFO has room |
| fifo_tx_empty | input | 1 | Master command FIFO is drained |
| fifo_rx_notempty | input | 1 | Master receive FIFO holds a byte |
| rx_pop | output | 1 | Pop the receive FIFO |
| rx_byte | input | 8 | Head of the receive FIFO |
| abrt_flag | input | 1 | Master reports a terminated transfer |
| abrt_addr_nack | input | 1 | Abort cause: address not acknowledged |
| abrt_data_nack | input | 1 | Abort cause: data not acknowledged |
| wr_valid | input | 1 | Write stream byte available |
| wr_data | input | 8 | Write stream byte |
| wr_take | output | 1 | Write stream byte consumed |
| rd_valid | output | 1 | Read stream byte strobe |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle end-of-transaction strobe |
| result | output | 5 | OR-ed result code |

## Verification
The hardest case to reach from the ports is the stuck-enable path. The master must keep reporting itself enabled through every poll after the enable falls. The bench gets there with a forced mode in its enable-status model: it keeps `ctl_enabled` high after an otherwise clean write. With POLLS and GAP_CYC shrunk, the bench then checks both the abort pulse and that the end comes only after the full poll window. The error-priority and skip-the-rest cases come from a bench master model whose abort causes can be armed per scenario. The model also raises an address NACK in place of receive data after a read command.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_LOAD, S_WBYTE, S_WDRAIN,
    S_RCMD, S_RWAIT, S_FINI, S_GAP, S_DONE
  } seq_state_t;

  localparam int RES_W = 5;
  localparam logic [RES_W-1:0] RES_ADDR_NACK    = 5'h01;
  localparam logic [RES_W-1:0] RES_DATA_NACK    = 5'h02;
  localparam logic [RES_W-1:0] RES_HW_TIMEOUT   = 5'h04;
  localparam logic [RES_W-1:0] RES_WAIT_TIMEOUT = 5'h08;
  localparam logic [RES_W-1:0] RES_OTHER        = 5'h10;

  // Classify a terminated write: data NACK wins over address NACK.
  function automatic logic [RES_W-1:0] abort_code(input logic addr_nack,
                                                  input logic data_nack);
    if (data_nack)      return RES_DATA_NACK;
    else if (addr_nack) return RES_ADDR_NACK;
    else                return RES_OTHER;
  endfunction

  // True when a new message's address or direction differs from the recorded pair.
  function automatic logic pair_differs(input logic [9:0] old_addr, input logic old_dir,
                                        input logic [9:0] new_addr, input logic new_dir);
    return (old_addr != new_addr) || (old_dir != new_dir);
  endfunction

endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cseq_pair_track.sv
module i2cseq_pair_track
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       first,
  input  logic [9:0] addr,
  input  logic       dir,
  output logic       change
);
  logic [9:0] rec_addr;
  logic       rec_dir;

  assign change = !first && pair_differs(rec_addr, rec_dir, addr, dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_addr <= '0;
      rec_dir  <= 1'b0;
    end else if (capture) begin
      rec_addr <= addr;
      rec_dir  <= dir;
    end
  end
endmodule

// File: rtl/i2c_msglist_seq.sv
module i2c_msglist_seq
  import i2cseq_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int WAIT_CYC = 2000000,
  parameter int POLLS    = 1000,
  parameter int GAP_CYC  = 2500,
  localparam int IDX_W   = $clog2(MAX_MSGS),
  localparam int CNT_W   = $clog2(MAX_MSGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  msg_count,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_rd,
  input  logic [LEN_W-1:0]  desc_len,
  output logic              ctl_enable,
  output logic [ADDR_W-1:0] ctl_target,
  input  logic              ctl_enabled,
  output logic              ctl_clear,
  output logic              ctl_abort,
  output logic              cmd_push,
  output logic [7:0]        cmd_byte,
  output logic              cmd_rd,
  output logic              cmd_stop,
  output logic              cmd_restart,
  input  logic              fifo_tx_notfull,
  input  logic              fifo_tx_empty,
  input  logic              fifo_rx_notempty,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              abrt_flag,
  input  logic              abrt_addr_nack,
  input  logic              abrt_data_nack,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  localparam int TMAX = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLLS + 1);

  seq_state_t        st, st_nxt;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  rem;
  logic              last_msg, restart_pend;
  logic [RES_W-1:0]  res;
  logic [PW-1:0]     polls;
  logic              en_r;
  logic [ADDR_W-1:0] tgt_r;

  // Named internal events (also observed by the checker)
  logic idx_is_last, waiting, push_w, push_r, drain_ok, tx_aborted;
  logic rx_nack, rx_got, wait_expired, err_clear, msg_end, last_poll;
  logic tmr_hit, tmr_clr, pair_change, in_cmd;

  assign idx_is_last = (CNT_W'(idx) + CNT_W'(1)) == msg_count;
  assign waiting     = (st == S_WBYTE) || (st == S_WDRAIN) || (st == S_RCMD) || (st == S_RWAIT);
  assign push_w      = (st == S_WBYTE) && wr_valid && fifo_tx_notfull;
  assign push_r      = (st == S_RCMD) && fifo_tx_notfull;
  assign drain_ok    = (st == S_WDRAIN) && fifo_tx_empty;
  assign tx_aborted  = drain_ok && abrt_flag;
  assign rx_nack     = (st == S_RWAIT) && abrt_addr_nack;
  assign rx_got      = (st == S_RWAIT) && !abrt_addr_nack && fifo_rx_notempty;
  assign wait_expired = waiting && tmr_hit && !(cmd_push || drain_ok || rx_nack || rx_got);
  assign err_clear   = tx_aborted || rx_nack;
  assign msg_end     = (drain_ok && !abrt_flag) || (rx_got && rem == '0);
  assign last_poll   = (polls == PW'(POLLS - 1));
  assign in_cmd      = (st == S_WBYTE) || (st == S_RCMD);

  assign tmr_clr = (st_nxt != st) || cmd_push;

  i2cseq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
    .limit((st == S_GAP) ? TW'(GAP_CYC) : TW'(WAIT_CYC)),
    .hit(tmr_hit)
  );

  i2cseq_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .capture(st == S_LOAD),
    .first(idx == '0), .addr(desc_addr), .dir(desc_rd), .change(pair_change)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:   if (go) st_nxt = (msg_count == '0) ? S_DONE : S_SCAN;
      S_SCAN:   if (desc_len == '0) st_nxt = S_DONE;
                else if (idx_is_last) st_nxt = S_LOAD;
      S_LOAD:   st_nxt = desc_rd ? S_RCMD : S_WBYTE;
      S_WBYTE:  if (push_w && rem == LEN_W'(1)) st_nxt = S_WDRAIN;
      S_WDRAIN: st_nxt = S_WDRAIN;
      S_RCMD:   if (push_r) st_nxt = S_RWAIT;
      S_RWAIT:  if (rx_got && rem != '0) st_nxt = S_RCMD;
      S_FINI:   st_nxt = (!ctl_enabled || last_poll) ? S_DONE : S_GAP;
      S_GAP:    if (tmr_hit) st_nxt = S_FINI;
      S_DONE:   st_nxt = S_IDLE;
      default:  st_nxt = S_IDLE;
    endcase
    if (wait_expired || err_clear) st_nxt = S_FINI;
    if (msg_end) st_nxt = last_msg ? S_FINI : S_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; rem <= '0; last_msg <= 1'b0; restart_pend <= 1'b0;
      res <= '0; polls <= '0; en_r <= 1'b0; tgt_r <= '0;
    end else begin
      st <= st_nxt;
      if (st == S_IDLE && go) begin
        idx <= '0;
        res <= (msg_count == '0) ? RES_OTHER : '0;
      end
      if (st == S_SCAN) begin
        if (desc_len == '0)   res <= RES_OTHER;
        else if (idx_is_last) idx <= '0;
        else                  idx <= idx + 1'b1;
      end
      if (st == S_LOAD) begin
        rem <= desc_len; last_msg <= idx_is_last; restart_pend <= pair_change;
        en_r <= 1'b1; tgt_r <= desc_addr;
      end
      if (cmd_push) begin
        rem <= rem - 1'b1;
        restart_pend <= 1'b0;
      end
      if (msg_end && !last_msg) idx <= idx + 1'b1;
      if (wait_expired) res <= res | RES_WAIT_TIMEOUT;
      if (err_clear) res <= res | (rx_nack ? RES_ADDR_NACK : abort_code(abrt_addr_nack, abrt_data_nack));
      if (st_nxt == S_FINI && st != S_FINI && st != S_GAP) begin
        en_r <= 1'b0;
        polls <= '0;
      end
      if (st == S_FINI && ctl_enabled) begin
        polls <= polls + 1'b1;
        if (last_poll) res <= res | RES_HW_TIMEOUT;
      end
    end
  end

  assign desc_idx    = idx;
  assign ctl_enable  = en_r;
  assign ctl_target  = tgt_r;
  assign ctl_clear   = (st == S_LOAD) || err_clear;
  assign ctl_abort   = (st == S_FINI) && ctl_enabled && last_poll;
  assign cmd_push    = push_w || push_r;
  assign cmd_byte    = (st == S_WBYTE) ? wr_data : 8'h00;
  assign cmd_rd      = (st == S_RCMD);
  assign cmd_stop    = in_cmd && last_msg && (rem == LEN_W'(1));
  assign cmd_restart = in_cmd && restart_pend;
  assign wr_take     = push_w;
  assign rx_pop      = rx_got;
  assign rd_valid    = rx_got;
  assign rd_data     = rx_byte;
  assign done        = (st == S_DONE);
  assign result      = res;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic ctl_enable,
  input logic ctl_enabled,
  input logic ctl_abort,
  input logic cmd_push,
  input logic cmd_rd,
  input logic cmd_stop,
  input logic cmd_restart,
  input logic fifo_tx_notfull,
  input logic fifo_rx_notempty,
  input logic wr_take,
  input logic rx_pop,
  input logic err_clear
);
  p_push_needs_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> fifo_tx_notfull);
  p_take_is_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (cmd_push && !cmd_rd));
  p_pop_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> fifo_rx_notempty);
  p_restart_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && cmd_restart) |=> !(cmd_push && cmd_restart));
  p_stop_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && cmd_stop) |=> !cmd_push);
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (!cmd_push && !ctl_enable));
  p_done_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_enable);
  p_abort_when_stuck_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_abort |-> ctl_enabled);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind i2c_msglist_seq i2cseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ctl_enable(ctl_enable),
  .ctl_enabled(ctl_enabled), .ctl_abort(ctl_abort), .cmd_push(cmd_push),
  .cmd_rd(cmd_rd), .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
  .fifo_tx_notfull(fifo_tx_notfull), .fifo_rx_notempty(fifo_rx_notempty),
  .wr_take(wr_take), .rx_pop(rx_pop), .err_clear(err_clear)
);

// File: tb/sim_i2c_msglist_seq.sv
module sim_i2c_msglist_seq;
  localparam int WAIT_CYC = 200;
  localparam int POLLS    = 4;
  localparam int GAP_CYC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       go = 1'b0;
  logic [2:0] msg_count = '0;
  logic [1:0] b_idx;
  logic [9:0] desc_addr;
  logic       desc_rd;
  logic [7:0] desc_len;
  logic       ctl_enable, ctl_clear, ctl_abort, cmd_push, cmd_rd, cmd_stop, cmd_restart;
  logic [9:0] ctl_target;
  logic [7:0] cmd_byte, rd_data;
  logic       rx_pop, wr_take, rd_valid, done;
  logic [4:0] result;

  // bench controls and master model
  logic [9:0] d_addr [4];
  logic       d_rd   [4];
  logic [7:0] d_len  [4];
  logic       tx_nf = 1'b1, stuck = 1'b0, nack_mode = 1'b0;
  logic       w_flag = 1'b0, w_addr = 1'b0, w_data = 1'b0, clr_log = 1'b0;
  logic [7:0] wbase = 8'h11, rbase = 8'hC0;
  logic [2:0] busy;
  logic [2:0] rx_dly;
  logic       rx_ne, rd_nack, en_mirror;
  int         wcount, rcount, npush, nrd, nclr, nabort, ndone, en_seen;
  logic [4:0] last_res;
  logic [7:0] lg_byte [16];
  logic       lg_rd [16], lg_stop [16], lg_rst [16];
  logic [9:0] lg_tgt [16];
  logic [7:0] rlog [16];

  assign desc_addr = d_addr[b_idx];
  assign desc_rd   = d_rd[b_idx];
  assign desc_len  = d_len[b_idx];

  i2c_msglist_seq #(.MAX_MSGS(4), .WAIT_CYC(WAIT_CYC), .POLLS(POLLS), .GAP_CYC(GAP_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .msg_count(msg_count), .desc_idx(b_idx),
    .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_len(desc_len),
    .ctl_enable(ctl_enable), .ctl_target(ctl_target), .ctl_enabled(en_mirror),
    .ctl_clear(ctl_clear), .ctl_abort(ctl_abort), .cmd_push(cmd_push), .cmd_byte(cmd_byte),
    .cmd_rd(cmd_rd), .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
    .fifo_tx_notfull(tx_nf), .fifo_tx_empty(busy == 3'd0), .fifo_rx_notempty(rx_ne),
    .rx_pop(rx_pop), .rx_byte(rbase + 8'(rcount)), .abrt_flag(w_flag),
    .abrt_addr_nack(w_addr || rd_nack), .abrt_data_nack(w_data),
    .wr_valid(1'b1), .wr_data(wbase + 8'(wcount)), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .result(result)
  );

  always @(posedge clk) begin
    en_mirror <= stuck ? 1'b1 : ctl_enable;
    if (cmd_push) busy <= 3'd3; else if (busy != 0) busy <= busy - 3'd1;
    if (cmd_push && cmd_rd) rx_dly <= 3'd3;
    else if (rx_dly > 3'd1) rx_dly <= rx_dly - 3'd1;
    else if (rx_dly == 3'd1) begin
      rx_dly <= 3'd0;
      if (nack_mode) rd_nack <= 1'b1; else rx_ne <= 1'b1;
    end
    if (rx_pop) begin rx_ne <= 1'b0; rcount <= rcount + 1; end
    if (wr_take) wcount <= wcount + 1;
    if (cmd_push) begin
      lg_byte[npush[3:0]] <= cmd_byte; lg_rd[npush[3:0]] <= cmd_rd;
      lg_stop[npush[3:0]] <= cmd_stop; lg_rst[npush[3:0]] <= cmd_restart;
      lg_tgt[npush[3:0]] <= ctl_target; npush <= npush + 1;
    end
    if (rd_valid) begin rlog[nrd[3:0]] <= rd_data; nrd <= nrd + 1; end
    if (ctl_clear) nclr <= nclr + 1;
    if (ctl_abort) nabort <= nabort + 1;
    if (ctl_enable) en_seen <= 1;
    if (done) begin ndone <= ndone + 1; last_res <= result; end
    if (clr_log) begin
      npush <= 0; nrd <= 0; nclr <= 0; nabort <= 0; ndone <= 0; en_seen <= 0;
      wcount <= 0; rcount <= 0; rd_nack <= 1'b0; rx_ne <= 1'b0; rx_dly <= 3'd0; busy <= 3'd0;
    end
  end

  int checks = 0, errors = 0, tick = 0;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick == 150000) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_msg(input int i, input logic [9:0] a, input logic rd, input logic [7:0] n);
    d_addr[i] = a; d_rd[i] = rd; d_len[i] = n;
  endtask

  task automatic run(input int n, output int cyc);
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0; msg_count = 3'(n); go = 1'b1;
    @(negedge clk); go = 1'b0; cyc = 1;
    while (ndone == 0 && cyc < 5000) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 done at reset", int'(done), 0);
    chk("R9 enable at reset", int'(ctl_enable), 0);
    chk("R4 push at reset", int'(cmd_push), 0);
  endtask

  task automatic t_single_write;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd3);
    run(1, c);
    chk("R4 push count", npush, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 write byte order", int'(lg_byte[i]), int'(wbase) + i);
      chk("R4 write cmd_rd", int'(lg_rd[i]), 0);
      chk("R2 stop only last", int'(lg_stop[i]), (i == 2) ? 1 : 0);
      chk("R1 no restart first msg", int'(lg_rst[i]), 0);
      chk("R11 target", int'(lg_tgt[i]), 'h50);
    end
    chk("R10 clean result", int'(last_res), 0);
    chk("R10 done single cycle", ndone, 1);
  endtask

  task automatic t_write_then_read;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd1);
    set_msg(1, 10'h050, 1'b1, 8'd2);
    run(2, c);
    chk("R6 push count", npush, 3);
    chk("R1 restart on dir change", int'(lg_rst[1]), 1);
    chk("R1 restart first byte only", int'(lg_rst[2]), 0);
    chk("R6 read cmds", int'(lg_rd[1]) + int'(lg_rd[2]), 2);
    chk("R2 stop write msg", int'(lg_stop[0]), 0);
    chk("R2 stop mid read", int'(lg_stop[1]), 0);
    chk("R2 stop last read", int'(lg_stop[2]), 1);
    chk("R6 read count", nrd, 2);
    chk("R6 read byte 0", int'(rlog[0]), int'(rbase));
    chk("R6 read byte 1", int'(rlog[1]), int'(rbase) + 1);
    chk("R10 clean result", int'(last_res), 0);
  endtask

  task automatic t_addr_change;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd1);
    set_msg(1, 10'h050, 1'b0, 8'd1);
    set_msg(2, 10'h051, 1'b0, 8'd2);
    run(3, c);
    chk("R1 push count", npush, 4);
    chk("R1 same pair no restart", int'(lg_rst[1]), 0);
    chk("R1 addr change restart", int'(lg_rst[2]), 1);
    chk("R1 restart once", int'(lg_rst[3]), 0);
    chk("R2 stop count", int'(lg_stop[0]) + int'(lg_stop[1]) + int'(lg_stop[2]), 0);
    chk("R2 stop last", int'(lg_stop[3]), 1);
    chk("R11 target msg1", int'(lg_tgt[1]), 'h50);
    chk("R11 target msg2", int'(lg_tgt[3]), 'h51);
    chk("R8 clear per message", nclr, 3);
  endtask

  task automatic t_zero_len;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd2);
    set_msg(1, 10'h051, 1'b0, 8'd0);
    run(2, c);
    chk("R3 zero len result", int'(last_res), 'h10);
    chk("R3 zero len no push", npush, 0);
    chk("R3 zero len no enable", en_seen, 0);
    run(0, c);
    chk("R3 empty list result", int'(last_res), 'h10);
    chk("R3 empty list no enable", en_seen, 0);
  endtask

  task automatic t_read_nack;
    int c;
    set_msg(0, 10'h052, 1'b1, 8'd2);
    set_msg(1, 10'h053, 1'b0, 8'd1);
    nack_mode = 1'b1;
    run(2, c);
    nack_mode = 1'b0;
    chk("R6 addr nack result", int'(last_res), 'h01);
    chk("R8 rest skipped", npush, 1);
    chk("R8 clear on error", nclr, 2);
    chk("R6 no read data", nrd, 0);
  endtask

  task automatic t_write_abort(input logic f, input logic a, input logic d, input int exp);
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd2);
    set_msg(1, 10'h050, 1'b0, 8'd1);
    w_flag = f; w_addr = a; w_data = d;
    run(2, c);
    w_flag = 1'b0; w_addr = 1'b0; w_data = 1'b0;
    chk("R5 abort classification", int'(last_res), exp);
    chk("R8 rest skipped after abort", npush, 2);
  endtask

  task automatic t_wait_timeout;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd2);
    tx_nf = 1'b0;
    run(1, c);
    tx_nf = 1'b1;
    chk("R7 wait timeout result", int'(last_res), 'h08);
    chk("R7 no push when full", npush, 0);
    chk("R7 waited full window", int'(c >= WAIT_CYC), 1);
  endtask

  task automatic t_stuck_enable;
    int c;
    set_msg(0, 10'h050, 1'b0, 8'd1);
    stuck = 1'b1;
    run(1, c);
    stuck = 1'b0;
    chk("R9 stuck result", int'(last_res), 'h04);
    chk("R9 abort pulse", nabort, 1);
    chk("R9 poll window", int'(c >= POLLS * GAP_CYC), 1);
    chk("R9 enable dropped", int'(ctl_enable), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) set_msg(i, 10'h000, 1'b0, 8'd1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single_write();
    t_write_then_read();
    t_addr_change();
    t_zero_len();
    t_read_nack();
    t_write_abort(1'b1, 1'b1, 1'b1, 'h02);
    t_write_abort(1'b1, 1'b1, 1'b0, 'h01);
    t_write_abort(1'b1, 1'b0, 1'b0, 'h10);
    t_wait_timeout();
    t_stuck_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule